// File: doc/BRIEF.md
# Scan-Accessed Debug Communication Registers

This block is a small bank of debug registers that an external debugger reaches through a serial scan path, one bit at a time. The host side first loads a chain number to pick a register. It then runs a capture, shift and update sequence. A mode qualifier (INTEST or EXTEST) decides whether the update writes anything and whether a capture has a side effect. The bank holds four things:

- a status/control word;
- an inbound data word with an empty flag;
- an outbound data word with a valid flag;
- an instruction word with a Ready handshake.

The core side sees plain single-cycle strobes: read the inbound word, write the outbound word, take an issued instruction and report its completion. A restart request and its acknowledge use the same kind of strobes.

The handshake flags change as side effects of scan accesses. An EXTEST update of the data chain fills the inbound word and clears its empty flag. An INTEST capture of the data chain consumes the outbound word. An instruction goes to the core only while the execute-enable control bit is set and Ready is 1. A restart clears the restarted status bit, and that bit is set again when the core acknowledges. The host polls it through the status chain.

Top module: `dbg_scan_regs`

## Requirements
- R1: After reset the selected chain is 0 (none). The inbound empty flag is 1, the outbound valid flag is 0, Ready is 1, the control word and restarted bit are 0, `host_tdo` is 0, `core_instr_valid` is 0 and `core_restart_req` is 0.
- R2: The shift register is 33 bits wide. `host_tdo` is its bit 0, and each shift strobe moves `host_tdi` into bit 32. Bit 0 carries the flag and bits 32:1 carry the data word. Chain 1 selects the status/control word, chain 4 the instruction word and chain 5 the data pair.
- R3: An EXTEST update on chain 5 loads shift bits 32:1 into `core_in_data` and clears `core_in_empty` on the next cycle. A `core_in_rd` strobe sets `core_in_empty` on the next cycle.
- R4: A `core_out_wr` strobe stores `core_out_wdata` and sets the outbound valid flag. A capture on chain 5 loads {outbound word, valid} into the shift register. An INTEST capture also clears the valid flag.
- R5: A capture on chain 4 loads zeros into bits 32:1 and Ready into bit 0. Ready is 0 from the issue of an instruction until `core_instr_done`.
- R6: An EXTEST update on chain 4 drives `core_instr_valid` high for exactly one cycle, with shift bits 32:1 on `core_instr`. This happens only if control bit 13 (execute enable) is 1 and Ready is 1; otherwise the word is dropped.
- R7: An EXTEST update on chain 1 writes every control bit except bit 1. A capture on chain 1 returns {control word with bit 1 replaced by the restarted flag, 1'b0}.
- R8: A `host_restart` strobe clears the restarted bit, raises `core_restart_req` and holds Ready at 0. A `core_restart_ack` while the request is pending drops the request and sets the restarted bit.
- R9: A chain number other than 1, 4 and 5 captures all zeros, and its updates change no register.
- R10: An update in INTEST mode changes no register on any chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_chain_sel | input | 1 | Load `host_chain_num` as the selected chain |
| host_chain_num | input | 4 | Chain number to select |
| host_extest | input | 1 | 1 = EXTEST, 0 = INTEST, sampled at capture and update |
| host_capture | input | 1 | Capture the selected register into the shift register |
| host_shift | input | 1 | Shift one bit, LSB out |
| host_update | input | 1 | Apply the shift register to the selected register |
| host_tdi | input | 1 | Serial data in |
| host_restart | input | 1 | Restart request strobe |
| host_tdo | output | 1 | Serial data out (shift bit 0) |
| core_in_rd | input | 1 | Core consumes the inbound word |
| core_in_data | output | 32 | Inbound data word |
| core_in_empty | output | 1 | Inbound word holds no unread data |
| core_out_wr | input | 1 | Core writes the outbound word |
| core_out_wdata | input | 32 | Outbound data to store |
| core_instr_valid | output | 1 | One-cycle instruction issue pulse |
| core_instr | output | 32 | Issued instruction word |
| core_instr_done | input | 1 | Core finished the issued instruction |
| core_restart_req | output | 1 | Restart request pending |
| core_restart_ack | input | 1 | Core acknowledges the restart |

## Verification
The assertions assume that at most one of chain select, capture, shift and update is active in a cycle. They also assume that the core reports completion only while an instruction is outstanding and acknowledges a restart only while one is requested. The stimulus keeps to these rules: every scan step is driven by a single task that raises one strobe per cycle, and the core-side strobes are raised only after the matching request is seen at the ports. Under these assumptions the checks cover the flag transitions, the gating of instruction issue, and the restart status bit.

// File: rtl/dbg_scan_pkg.sv
// Shared constants for the scan-accessed debug register bank.
// Assumes a single clock domain; chain numbers are fixed by the host protocol.
package dbg_scan_pkg;
    localparam int DATA_W  = 32;
    localparam int CHAIN_W = 4;

    localparam logic [CHAIN_W-1:0] CH_NONE = 4'd0;
    localparam logic [CHAIN_W-1:0] CH_CTRL = 4'd1;
    localparam logic [CHAIN_W-1:0] CH_INSN = 4'd4;
    localparam logic [CHAIN_W-1:0] CH_DATA = 4'd5;

    localparam int RESTARTED_BIT = 1;
    localparam int EXEC_EN_BIT   = 13;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_INSN,
        SEL_DATA
    } chain_sel_e;
endpackage

// File: rtl/dbg_scan_shift.sv
// Chain select register, shared shift register and capture/update decode.
// Assumes at most one host strobe (select, capture, shift, update) per cycle.
module dbg_scan_shift
    import dbg_scan_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_sel,
    input  logic [CW-1:0] chain_num,
    input  logic          extest,
    input  logic          capture,
    input  logic          shift,
    input  logic          update,
    input  logic          tdi,
    input  logic [DW:0]   ctrl_cap,
    input  logic [DW:0]   insn_cap,
    input  logic [DW:0]   data_cap,
    output logic          tdo,
    output logic [DW-1:0] upd_word,
    output logic          upd_ctrl,
    output logic          upd_insn,
    output logic          upd_data,
    output logic          cap_data_int
);
    localparam int SW = DW + 1;

    logic [CW-1:0] chain_q;
    logic [SW-1:0] sr_q;
    chain_sel_e    sel;

    // Map the stored chain number onto an implemented register.
    always_comb begin
        unique case (chain_q)
            CH_CTRL: sel = SEL_CTRL;
            CH_INSN: sel = SEL_INSN;
            CH_DATA: sel = SEL_DATA;
            default: sel = SEL_NONE;
        endcase
    end

    // Hold the chain number picked by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= CH_NONE;
        else if (chain_sel)
            chain_q <= chain_num;
    end

    // Capture the selected register or shift one bit toward tdo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (capture) begin
            unique case (sel)
                SEL_CTRL: sr_q <= ctrl_cap;
                SEL_INSN: sr_q <= insn_cap;
                SEL_DATA: sr_q <= data_cap;
                default:  sr_q <= '0;
            endcase
        end else if (shift) begin
            sr_q <= {tdi, sr_q[SW-1:1]};
        end
    end

    // Decode update and capture side effects per chain and mode.
    always_comb begin
        upd_ctrl     = update && extest && (sel == SEL_CTRL);
        upd_insn     = update && extest && (sel == SEL_INSN);
        upd_data     = update && extest && (sel == SEL_DATA);
        cap_data_int = capture && !extest && (sel == SEL_DATA);
    end

    assign tdo      = sr_q[0];
    assign upd_word = sr_q[SW-1:1];

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chain_sel, capture, shift, update}));

    p_shift_in_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (sr_q[SW-1] == $past(tdi)));

    p_intest_no_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !extest) |-> !(upd_ctrl || upd_insn || upd_data));
endmodule

// File: rtl/dbg_scan_ctrl.sv
// Status and control word: host-writable bits plus the restarted status bit.
// Assumes the restarted flag comes from the instruction/restart unit.
module dbg_scan_ctrl
    import dbg_scan_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_ctrl,
    input  logic [DW-1:0] upd_word,
    input  logic          restarted,
    output logic [DW:0]   ctrl_cap,
    output logic          exec_en
);
    localparam logic [DW-1:0] WR_MASK = ~(DW'(1) << RESTARTED_BIT);

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] ctrl_rd;

    // Store the writable control bits on an EXTEST update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (upd_ctrl)
            ctrl_q <= upd_word & WR_MASK;
    end

    // Merge the live restarted flag into the readback word.
    always_comb begin
        ctrl_rd = ctrl_q;
        ctrl_rd[RESTARTED_BIT] = restarted;
    end

    assign ctrl_cap = {ctrl_rd, 1'b0};
    assign exec_en  = ctrl_q[EXEC_EN_BIT];

    p_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ctrl |=> (exec_en == $past(upd_word[EXEC_EN_BIT])));
endmodule

// File: rtl/dbg_scan_dtr.sv
// Inbound and outbound data words with their empty and valid flags.
// Assumes a host update and a core read of the inbound word do not coincide.
module dbg_scan_dtr
    import dbg_scan_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_data,
    input  logic [DW-1:0] upd_word,
    input  logic          cap_data_int,
    input  logic          core_in_rd,
    input  logic          core_out_wr,
    input  logic [DW-1:0] core_out_wdata,
    output logic [DW-1:0] in_data,
    output logic          in_empty,
    output logic [DW:0]   data_cap
);
    logic [DW-1:0] out_q;
    logic          out_valid;

    // Host fills the inbound word; a core read empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_data  <= '0;
            in_empty <= 1'b1;
        end else if (upd_data) begin
            in_data  <= upd_word;
            in_empty <= 1'b0;
        end else if (core_in_rd) begin
            in_empty <= 1'b1;
        end
    end

    // Core fills the outbound word; an INTEST capture consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= '0;
            out_valid <= 1'b0;
        end else if (core_out_wr) begin
            out_q     <= core_out_wdata;
            out_valid <= 1'b1;
        end else if (cap_data_int) begin
            out_valid <= 1'b0;
        end
    end

    assign data_cap = {out_q, out_valid};

    p_write_clears_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_data |=> !in_empty);

    p_read_sets_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_in_rd && !upd_data) |=> in_empty);

    p_core_write_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_out_wr |=> data_cap[0]);
endmodule

// File: rtl/dbg_scan_itr.sv
// Instruction issue with Ready handshake, and the restart request/acknowledge.
// Assumes done arrives only while an instruction is outstanding.
module dbg_scan_itr
    import dbg_scan_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_insn,
    input  logic [DW-1:0] upd_word,
    input  logic          exec_en,
    input  logic          host_restart,
    input  logic          core_instr_done,
    input  logic          core_restart_ack,
    output logic          instr_valid,
    output logic [DW-1:0] instr,
    output logic          restart_req,
    output logic          restarted,
    output logic [DW:0]   insn_cap
);
    logic busy;
    logic ready;

    assign ready = !busy && !restart_req;

    // Issue a scanned instruction when enabled and ready; track completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_valid <= 1'b0;
            instr       <= '0;
            busy        <= 1'b0;
        end else begin
            instr_valid <= 1'b0;
            if (upd_insn && exec_en && ready) begin
                instr_valid <= 1'b1;
                instr       <= upd_word;
                busy        <= 1'b1;
            end else if (busy && core_instr_done) begin
                busy <= 1'b0;
            end
        end
    end

    // Raise a restart request and record the core's acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_req <= 1'b0;
            restarted   <= 1'b0;
        end else if (host_restart) begin
            restart_req <= 1'b1;
            restarted   <= 1'b0;
        end else if (restart_req && core_restart_ack) begin
            restart_req <= 1'b0;
            restarted   <= 1'b1;
        end
    end

    assign insn_cap = {{DW{1'b0}}, ready};

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);

    p_issue_blocks_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !core_instr_done) |-> !insn_cap[0]);

    p_ack_sets_restarted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_req && core_restart_ack && !host_restart) |=> (restarted && !restart_req));

    p_restart_clears_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_restart |=> (!restarted && !insn_cap[0]));
endmodule

// File: rtl/dbg_scan_regs.sv
// Top of the scan-accessed debug register bank: wires the shift path to the
// control word, data pair and instruction unit. Assumes one clock domain.
module dbg_scan_regs
    import dbg_scan_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_chain_sel,
    input  logic [CW-1:0] host_chain_num,
    input  logic          host_extest,
    input  logic          host_capture,
    input  logic          host_shift,
    input  logic          host_update,
    input  logic          host_tdi,
    input  logic          host_restart,
    output logic          host_tdo,
    input  logic          core_in_rd,
    output logic [DW-1:0] core_in_data,
    output logic          core_in_empty,
    input  logic          core_out_wr,
    input  logic [DW-1:0] core_out_wdata,
    output logic          core_instr_valid,
    output logic [DW-1:0] core_instr,
    input  logic          core_instr_done,
    output logic          core_restart_req,
    input  logic          core_restart_ack
);
    logic [DW-1:0] upd_word;
    logic          upd_ctrl, upd_insn, upd_data, cap_data_int;
    logic [DW:0]   ctrl_cap, insn_cap, data_cap;
    logic          exec_en, restarted;

    dbg_scan_shift #(.DW(DW), .CW(CW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .chain_sel(host_chain_sel), .chain_num(host_chain_num),
        .extest(host_extest), .capture(host_capture),
        .shift(host_shift), .update(host_update), .tdi(host_tdi),
        .ctrl_cap(ctrl_cap), .insn_cap(insn_cap), .data_cap(data_cap),
        .tdo(host_tdo), .upd_word(upd_word),
        .upd_ctrl(upd_ctrl), .upd_insn(upd_insn), .upd_data(upd_data),
        .cap_data_int(cap_data_int)
    );

    dbg_scan_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .upd_ctrl(upd_ctrl), .upd_word(upd_word),
        .restarted(restarted), .ctrl_cap(ctrl_cap), .exec_en(exec_en)
    );

    dbg_scan_dtr #(.DW(DW)) u_dtr (
        .clk(clk), .rst_n(rst_n),
        .upd_data(upd_data), .upd_word(upd_word), .cap_data_int(cap_data_int),
        .core_in_rd(core_in_rd), .core_out_wr(core_out_wr),
        .core_out_wdata(core_out_wdata),
        .in_data(core_in_data), .in_empty(core_in_empty), .data_cap(data_cap)
    );

    dbg_scan_itr #(.DW(DW)) u_itr (
        .clk(clk), .rst_n(rst_n),
        .upd_insn(upd_insn), .upd_word(upd_word), .exec_en(exec_en),
        .host_restart(host_restart), .core_instr_done(core_instr_done),
        .core_restart_ack(core_restart_ack),
        .instr_valid(core_instr_valid), .instr(core_instr),
        .restart_req(core_restart_req), .restarted(restarted),
        .insn_cap(insn_cap)
    );

    p_issue_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_instr_valid |-> $past(exec_en));
endmodule

// File: tb/dbg_scan_regs_bench.sv
`timescale 1ns/1ps
module dbg_scan_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chain_sel = 0, extest = 0, cap = 0, sh = 0, upd = 0, tdi = 0, rst_req = 0;
    logic [3:0]  chain_num = 0;
    logic        tdo;
    logic        in_rd = 0, out_wr = 0, instr_done = 0, rs_ack = 0;
    logic [31:0] out_wdata = 0;
    logic [31:0] in_data, instr;
    logic        in_empty, instr_valid, rs_req;

    int n_cmp = 0;
    int n_bad = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [32:0] got_word;
    event        scan_ev;
    bit          finished = 0;

    always #4 clk = ~clk;

    dbg_scan_regs u_dbg_scan_regs (
        .clk(clk), .rst_n(rst_n),
        .host_chain_sel(chain_sel), .host_chain_num(chain_num),
        .host_extest(extest), .host_capture(cap), .host_shift(sh),
        .host_update(upd), .host_tdi(tdi), .host_restart(rst_req),
        .host_tdo(tdo),
        .core_in_rd(in_rd), .core_in_data(in_data), .core_in_empty(in_empty),
        .core_out_wr(out_wr), .core_out_wdata(out_wdata),
        .core_instr_valid(instr_valid), .core_instr(instr),
        .core_instr_done(instr_done),
        .core_restart_req(rs_req), .core_restart_ack(rs_ack)
    );

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Monitor: pop the expected captured word when a scan completes.
    initial begin
        forever begin
            @(scan_ev);
            if (exp_q.size() != 0)
                check(tag_q.pop_front(), got_word, exp_q.pop_front());
        end
    end

    // Driver: select chain, push expectation, capture, shift 33 bits, update.
    task automatic access(input logic [3:0] ch, input logic ext, input logic [32:0] din,
                          input logic [32:0] exp, input string req);
        @(negedge clk) chain_sel = 1; chain_num = ch;
        @(negedge clk) chain_sel = 0; extest = ext; cap = 1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk) cap = 0;
        for (int i = 0; i < 33; i++) begin
            got_word[i] = tdo;
            tdi = din[i];
            sh = 1;
            @(negedge clk);
        end
        sh = 0;
        upd = 1;
        @(negedge clk) upd = 0;
        ->scan_ev;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1;
        @(negedge clk) s = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 tdo", {32'd0, tdo}, 33'd0);
        check("R1 empty", {32'd0, in_empty}, 33'd1);
        check("R1 instr_valid", {32'd0, instr_valid}, 33'd0);
        check("R1 restart_req", {32'd0, rs_req}, 33'd0);
        // R9 unimplemented chain captures zeros, update ignored
        access(4'd0, 1, {32'hFFFF_FFFF, 1'b1}, 33'd0, "R9 chain0 capture");
        check("R9 empty after chain0 write", {32'd0, in_empty}, 33'd1);
        // R7 control word reads zero after reset
        access(4'd1, 0, 33'd0, 33'd0, "R7 ctrl reset read");
        // R3 inbound write
        access(4'd5, 1, {32'hA5A5_1234, 1'b0}, 33'd0, "R4 data capture empty");
        check("R3 in_data", {1'b0, in_data}, {1'b0, 32'hA5A5_1234});
        check("R3 empty cleared", {32'd0, in_empty}, 33'd0);
        pulse(in_rd);
        check("R3 empty set by read", {32'd0, in_empty}, 33'd1);
        // R4 outbound word
        @(negedge clk) out_wr = 1; out_wdata = 32'hC0DE_BEEF;
        @(negedge clk) out_wr = 0;
        access(4'd5, 0, 33'd0, {32'hC0DE_BEEF, 1'b1}, "R4 out valid");
        access(4'd5, 0, 33'd0, {32'hC0DE_BEEF, 1'b0}, "R4 valid cleared");
        // R5 Ready at idle
        access(4'd4, 0, 33'd0, 33'd1, "R5 ready idle");
        // R6 issue blocked while execute enable clear
        access(4'd4, 1, {32'h1111_2222, 1'b0}, 33'd1, "R5 ready before gated issue");
        check("R6 no issue when disabled", {32'd0, instr_valid}, 33'd0);
        // R7 control write, bit 1 read-only
        access(4'd1, 1, {32'hFFFF_FFFF, 1'b0}, 33'd0, "R7 ctrl before write");
        access(4'd1, 0, 33'd0, {32'hFFFF_FFFD, 1'b0}, "R7 ctrl readback");
        // R6 issue enabled
        access(4'd4, 1, {32'h3333_4444, 1'b0}, 33'd1, "R5 ready before issue");
        check("R6 instr_valid", {32'd0, instr_valid}, 33'd1);
        check("R6 instr", {1'b0, instr}, {1'b0, 32'h3333_4444});
        @(negedge clk);
        check("R6 single pulse", {32'd0, instr_valid}, 33'd0);
        // R5 busy: Ready 0, second issue dropped
        access(4'd4, 1, {32'h5555_6666, 1'b0}, 33'd0, "R5 ready low busy");
        check("R6 no issue while busy", {32'd0, instr_valid}, 33'd0);
        pulse(instr_done);
        access(4'd4, 0, 33'd0, 33'd1, "R5 ready after done");
        // R8 restart
        pulse(rst_req);
        check("R8 restart_req", {32'd0, rs_req}, 33'd1);
        access(4'd4, 0, 33'd0, 33'd0, "R8 ready low in restart");
        access(4'd1, 0, 33'd0, {32'hFFFF_FFFD, 1'b0}, "R8 restarted clear");
        pulse(rs_ack);
        check("R8 req dropped", {32'd0, rs_req}, 33'd0);
        access(4'd1, 0, 33'd0, {32'hFFFF_FFFF, 1'b0}, "R8 restarted set");
        access(4'd4, 0, 33'd0, 33'd1, "R8 ready back");
        // R10 INTEST update ignored
        access(4'd5, 0, {32'h0BAD_0BAD, 1'b0}, {32'hC0DE_BEEF, 1'b0}, "R10 data capture");
        check("R10 empty kept", {32'd0, in_empty}, 33'd1);
        check("R10 in_data kept", {1'b0, in_data}, {1'b0, 32'hA5A5_1234});
        access(4'd1, 0, 33'd0, {32'hFFFF_FFFF, 1'b0}, "R10 ctrl intest update");
        access(4'd1, 0, 33'd0, {32'hFFFF_FFFF, 1'b0}, "R10 ctrl unchanged");
        // R9 unimplemented chain 7 in EXTEST
        access(4'd7, 1, 33'd0, 33'd0, "R9 chain7 capture");
        check("R9 empty kept", {32'd0, in_empty}, 33'd1);
        access(4'd1, 0, 33'd0, {32'hFFFF_FFFF, 1'b0}, "R9 ctrl unchanged");
        // R2 tdo shows shift bit 0 after capture of chain 4 (Ready=1)
        @(negedge clk) chain_sel = 1; chain_num = 4'd4;
        @(negedge clk) chain_sel = 0; cap = 1; extest = 0;
        @(negedge clk) cap = 0;
        check("R2 tdo is bit0", {32'd0, tdo}, 33'd1);
        @(negedge clk) tdi = 0; sh = 1;
        @(negedge clk) sh = 0;
        check("R2 shifted out", {32'd0, tdo}, 33'd0);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule